// File: doc/BRIEF.md
# DRAM Open-Page Tracker

This block holds the open-row state of one DRAM channel: for every rank and bank it remembers whether a row is open and which row that is. A requester presents a rank, bank and row, and one clock later the block reports whether the access would be a page hit, a page miss (bank closed) or a page conflict (a different row is open). The command scheduler feeds the block the commands it has issued: activate, precharge of one bank, precharge of a whole rank, and refresh. The tracker's state therefore mirrors the DRAM.

Two static configuration inputs adapt the block to the installed devices. Lower-density parts have four banks and 8K rows. For those parts the top bank index bit marks an illegal bank, and the top row bit is ignored. Higher-density parts use all eight banks and 16K rows. A refresh closes every page of its rank before it is reported as issued. A population count of the open entries is available at all times.

Top module: `page_state_tracker`

## Requirements
- R1: While reset is asserted, and at the first sample after it, all 32 entries are closed, `open_count` is 0 and every result and flag output is 0.
- R2: When `lk_valid` is high, the next cycle has `res_valid`=1 and `res_class` equal to 2'b01 (hit) if the bank is open with the same row, 2'b10 (conflict) if it is open with another row, and 2'b00 (miss) if it is closed. The value 2'b11 never appears.
- R3: When a lookup and a command arrive in the same cycle, the lookup is classified against the state from before that command.
- R4: With `cfg_eight_bank`=0, bank index bit 2 marks an illegal bank. A lookup to such a bank returns `res_bad_bank`=1 with class miss. An activate or precharge to it changes no state and pulses `err_bank` in the next cycle.
- R5: `cmd_op`=3'b001 (activate) opens the addressed bank and records its row.
- R6: `cmd_op`=3'b010 (precharge) closes only the addressed bank.
- R7: `cmd_op`=3'b011 (precharge all) closes every bank of `cmd_rank`. `cmd_op`=3'b100 (refresh) does the same and pulses `ref_done` in the next cycle. Other opcodes are no-ops.
- R8: An activate to a bank that is already open pulses `err_reopen` in the next cycle, and the new row replaces the stored one.
- R9: With `cfg_wide_row`=0, row bit 13 is ignored both when a row is stored and when rows are compared.
- R10: `open_count` equals the number of open entries (0 to 32) and follows each command in the same cycle that the state changes.
- R11: With `cfg_eight_bank`=1, banks 0 to 7 of all four ranks are tracked independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_eight_bank | input | 1 | 1: eight banks per rank; 0: four banks |
| cfg_wide_row | input | 1 | 1: 14-bit rows; 0: 13-bit rows |
| lk_valid | input | 1 | Lookup request |
| lk_rank | input | 2 | Lookup rank |
| lk_bank | input | 3 | Lookup bank |
| lk_row | input | 14 | Lookup row |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_class | output | 2 | 00 miss, 01 hit, 10 conflict |
| res_bad_bank | output | 1 | The lookup addressed a bank the configuration does not have |
| cmd_valid | input | 1 | Command event |
| cmd_op | input | 3 | 001 activate, 010 precharge, 011 precharge all, 100 refresh |
| cmd_rank | input | 2 | Command rank |
| cmd_bank | input | 3 | Command bank |
| cmd_row | input | 14 | Row opened by an activate |
| err_reopen | output | 1 | Activate to an already open bank |
| err_bank | output | 1 | Activate or precharge to an illegal bank |
| ref_done | output | 1 | Refresh issued; its rank is closed |
| open_count | output | 6 | Number of open pages |

## Verification
The case that matters is a lookup and a state-changing command to the same bank in the same cycle. The bench drives both on one edge: an activate under a lookup to a closed bank, and a precharge under a lookup to an open bank. The result must reflect the old state, so it is a miss for the first and a hit for the second. The lookup that follows must then show the new state. Each expected value comes from a bench-side model that is classified before it is updated.

// File: rtl/page_state_tracker.sv
`timescale 1ns/1ps
module page_state_tracker #(
  parameter int RANKS = 4,
  parameter int BANKS = 8,
  parameter int ROW_W = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_eight_bank,
  input  logic                                cfg_wide_row,
  input  logic                                lk_valid,
  input  logic [$clog2(RANKS)-1:0]            lk_rank,
  input  logic [$clog2(BANKS)-1:0]            lk_bank,
  input  logic [ROW_W-1:0]                    lk_row,
  output logic                                res_valid,
  output logic [1:0]                          res_class,
  output logic                                res_bad_bank,
  input  logic                                cmd_valid,
  input  logic [2:0]                          cmd_op,
  input  logic [$clog2(RANKS)-1:0]            cmd_rank,
  input  logic [$clog2(BANKS)-1:0]            cmd_bank,
  input  logic [ROW_W-1:0]                    cmd_row,
  output logic                                err_reopen,
  output logic                                err_bank,
  output logic                                ref_done,
  output logic [$clog2(RANKS*BANKS+1)-1:0]    open_count
);
  localparam int RANK_W  = $clog2(RANKS);
  localparam int BANK_W  = $clog2(BANKS);
  localparam int ENTRIES = RANKS * BANKS;
  localparam int IDX_W   = RANK_W + BANK_W;
  localparam int CNT_W   = $clog2(ENTRIES + 1);
  localparam logic [1:0] C_MISS = 2'b00, C_HIT = 2'b01, C_CONF = 2'b10;
  localparam logic [2:0] OP_ACT = 3'b001, OP_PRE = 3'b010, OP_PREA = 3'b011, OP_REF = 3'b100;

  logic [ENTRIES-1:0] vld, vld_nx;
  logic [ROW_W-1:0]   rows [ENTRIES];
  logic [RANKS-1:0]   rank_any;
  logic [CNT_W-1:0]   cnt;

  wire [IDX_W-1:0] lk_idx  = {lk_rank, lk_bank};
  wire [IDX_W-1:0] cmd_idx = {cmd_rank, cmd_bank};
  wire [ROW_W-1:0] row_mask = cfg_wide_row ? {ROW_W{1'b1}} : {1'b0, {(ROW_W-1){1'b1}}};

  wire lk_bad  = !cfg_eight_bank && lk_bank[BANK_W-1];
  wire cmd_bad = !cfg_eight_bank && cmd_bank[BANK_W-1];

  wire is_act  = cmd_valid && cmd_op == OP_ACT;
  wire is_pre  = cmd_valid && cmd_op == OP_PRE;
  wire is_prea = cmd_valid && cmd_op == OP_PREA;
  wire is_ref  = cmd_valid && cmd_op == OP_REF;
  wire act_ok  = is_act && !cmd_bad;
  wire pre_ok  = is_pre && !cmd_bad;
  wire rank_close = is_prea || is_ref;

  wire row_match = (rows[lk_idx] & row_mask) == (lk_row & row_mask);

  always_comb begin
    vld_nx = vld;
    for (int e = 0; e < ENTRIES; e++)
      if (rank_close && (e / BANKS) == int'(cmd_rank)) vld_nx[e] = 1'b0;
    if (act_ok) vld_nx[cmd_idx] = 1'b1;
    if (pre_ok) vld_nx[cmd_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else        vld <= vld_nx;
  end

  always_ff @(posedge clk)
    if (act_ok) rows[cmd_idx] <= cmd_row & row_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_class    <= C_MISS;
      res_bad_bank <= 1'b0;
      err_reopen   <= 1'b0;
      err_bank     <= 1'b0;
      ref_done     <= 1'b0;
    end else begin
      res_valid    <= lk_valid;
      res_bad_bank <= lk_valid && lk_bad;
      if (!lk_valid || lk_bad || !vld[lk_idx]) res_class <= C_MISS;
      else                                     res_class <= row_match ? C_HIT : C_CONF;
      err_reopen   <= act_ok && vld[cmd_idx];
      err_bank     <= (is_act || is_pre) && cmd_bad;
      ref_done     <= is_ref;
    end
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    assign rank_any[r] = |vld[r*BANKS +: BANKS];
  end

  always_comb begin
    cnt = '0;
    for (int e = 0; e < ENTRIES; e++) cnt = cnt + CNT_W'(vld[e]);
  end
  assign open_count = cnt;

  a_r2_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_class != 2'b11);
  a_r4_bad_lookup_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_bad_bank |-> res_class == C_MISS && res_valid);
  a_r4_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_act || is_pre) && cmd_bad) |=> vld == $past(vld));
  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok |=> vld[$past(cmd_idx)]);
  a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ok |=> !vld[$past(cmd_idx)]);
  a_r7_rank_closed: assert property (@(posedge clk) disable iff (!rst_n)
    rank_close |=> !rank_any[$past(cmd_rank)]);
  a_r7_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> $past(is_ref));
  a_r8_reopen_source: assert property (@(posedge clk) disable iff (!rst_n)
    err_reopen |-> $past(is_act));
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    open_count <= CNT_W'(ENTRIES));
endmodule

// File: tb/sim_page_state_tracker.sv
`timescale 1ns/1ps
module sim_page_state_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_eight_bank = 1'b1, cfg_wide_row = 1'b1;
  logic lk_valid = 1'b0;
  logic [1:0] lk_rank = '0;
  logic [2:0] lk_bank = '0;
  logic [13:0] lk_row = '0;
  logic res_valid, res_bad_bank, err_reopen, err_bank, ref_done;
  logic [1:0] res_class;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_rank = '0;
  logic [2:0] cmd_bank = '0;
  logic [13:0] cmd_row = '0;
  logic [5:0] open_count;

  int total = 0, fails = 0;
  bit mv [4][8];
  logic [13:0] mr [4][8];

  always #2.5 clk = ~clk;

  page_state_tracker u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [13:0] rowf(input int r, input int b);
    return 14'((r * 8 + b) * 517);
  endfunction

  function automatic logic [13:0] msk(input logic [13:0] v);
    return cfg_wide_row ? v : (v & 14'h1fff);
  endfunction

  function automatic bit mbad(input int b);
    return !cfg_eight_bank && b >= 4;
  endfunction

  function automatic int mcount();
    int n = 0;
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) n += int'(mv[r][b]);
    return n;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) begin mv[r][b] = 1'b0; mr[r][b] = '0; end
  endtask

  task automatic cyc(input string tag, input bit lv, input int lr, input int lb, input logic [13:0] lrow,
                     input bit cv, input int op, input int cr, input int cb, input logic [13:0] crow);
    int e_cls, e_cnt;
    bit e_bad, e_reo, e_eb, e_ref, act, pre;
    lk_valid = lv; lk_rank = 2'(lr); lk_bank = 3'(lb); lk_row = lrow;
    cmd_valid = cv; cmd_op = 3'(op); cmd_rank = 2'(cr); cmd_bank = 3'(cb); cmd_row = crow;
    e_bad = lv && mbad(lb);
    if (!lv || e_bad || !mv[lr][lb]) e_cls = 0;
    else e_cls = (mr[lr][lb] == msk(lrow)) ? 1 : 2;
    act = cv && op == 1; pre = cv && op == 2;
    e_eb  = (act || pre) && mbad(cb);
    e_reo = act && !mbad(cb) && mv[cr][cb];
    e_ref = cv && op == 4;
    if (act && !mbad(cb)) begin mv[cr][cb] = 1'b1; mr[cr][cb] = msk(crow); end
    if (pre && !mbad(cb)) mv[cr][cb] = 1'b0;
    if (cv && (op == 3 || op == 4)) for (int b = 0; b < 8; b++) mv[cr][b] = 1'b0;
    e_cnt = mcount();
    @(posedge clk); #1;
    lk_valid = 1'b0; cmd_valid = 1'b0;
    chk(tag, "res_valid", int'(res_valid), int'(lv));
    chk(tag, "res_class", int'(res_class), e_cls);
    chk(tag, "res_bad_bank", int'(res_bad_bank), int'(e_bad));
    chk(tag, "err_reopen", int'(err_reopen), int'(e_reo));
    chk(tag, "err_bank", int'(err_bank), int'(e_eb));
    chk(tag, "ref_done", int'(ref_done), int'(e_ref));
    chk(tag, "open_count", int'(open_count), e_cnt);
  endtask

  task automatic look(input string tag, input int r, input int b, input logic [13:0] row);
    cyc(tag, 1'b1, r, b, row, 1'b0, 0, 0, 0, '0);
  endtask

  task automatic cmd(input string tag, input int op, input int r, input int b, input logic [13:0] row);
    cyc(tag, 1'b0, 0, 0, '0, 1'b1, op, r, b, row);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    model_clear();
    chk("R1", "open_count", int'(open_count), 0);
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "flags", int'({err_reopen, err_bank, ref_done, res_bad_bank}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "open_count after release", int'(open_count), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    do_reset();
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) look("R2", r, b, rowf(r, b));
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) cmd("R11", 1, r, b, rowf(r, b));
    chk("R10", "full count", int'(open_count), 32);
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) begin
      look("R2", r, b, rowf(r, b));
      look("R2", r, b, rowf(r, b) ^ 14'h0100);
    end
    cmd("R8", 1, 0, 3, 14'h2aaa);
    look("R8", 0, 3, 14'h2aaa);
    look("R8", 0, 3, rowf(0, 3));
    cmd("R6", 2, 0, 3, '0);
    look("R6", 0, 3, 14'h2aaa);
    look("R6", 0, 2, rowf(0, 2));
    cyc("R3", 1'b1, 0, 3, 14'h0777, 1'b1, 1, 0, 3, 14'h0777);
    look("R3", 0, 3, 14'h0777);
    cyc("R3", 1'b1, 1, 2, rowf(1, 2), 1'b1, 2, 1, 2, '0);
    look("R3", 1, 2, rowf(1, 2));
    cmd("R7", 5, 1, 0, '0);
    cmd("R7", 3, 1, 0, '0);
    for (int b = 0; b < 8; b++) look("R7", 1, b, rowf(1, b));
    look("R7", 2, 5, rowf(2, 5));
    cmd("R7", 4, 2, 6, '0);
    for (int b = 0; b < 8; b++) look("R7", 2, b, rowf(2, b));
    look("R7", 3, 7, rowf(3, 7));

    cfg_eight_bank = 1'b0; cfg_wide_row = 1'b0;
    do_reset();
    cmd("R9", 1, 3, 1, 14'h2005);
    look("R9", 3, 1, 14'h0005);
    look("R9", 3, 1, 14'h2005);
    look("R9", 3, 1, 14'h0006);
    look("R4", 0, 5, '0);
    cmd("R4", 1, 0, 6, 14'h0012);
    look("R4", 0, 2, 14'h0012);
    cmd("R4", 2, 3, 5, '0);
    look("R4", 3, 1, 14'h0005);
    for (int r = 0; r < 4; r++) for (int b = 0; b < 4; b++) cmd("R5", 1, r, b, rowf(r, b));
    for (int r = 0; r < 4; r++) for (int b = 0; b < 8; b++) look("R4", r, b, rowf(r, b));
    cmd("R8", 1, 2, 0, 14'h3fff);
    look("R9", 2, 0, 14'h1fff);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule